// File: doc/BRIEF.md
# Sequential Signed Shift-and-Add Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns a signed product of `2*WIDTH` bits. It does not build an array of adders. It keeps a running sum in a register and takes one multiplier bit per clock, starting at the least significant bit. On each step it adds the multiplicand, sign-extended to the full product width and shifted to the weight of that bit, or it adds zero when the bit is clear.

The top multiplier bit carries a negative weight. On the final step the block therefore adds the two's-complement negation of the shifted multiplicand. Any carry out of the top product bit is dropped. A caller pulses `start_i` while the block is idle, with the operands valid in the same cycle. It then waits for the one-cycle `done_o` pulse and reads `product_o`, which keeps its value until the next result is written.

Top module: `seq_smul`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: When `start_i` is high at a clock edge while the block is idle, the operands are captured and `busy_o` is 1 from that edge on.
- R3: `busy_o` stays high for exactly `WIDTH` cycles. At the edge that clears it, `done_o` goes high.
- R4: `done_o` is high for exactly one cycle and is never high together with `busy_o`.
- R5: When `done_o` is high, `product_o` equals the signed product of the two captured operands, written as `2*WIDTH`-bit two's complement. This holds for every operand pair.
- R6: The multiplier's top bit has weight -2^(WIDTH-1). For WIDTH=4: (-8)*(-8) gives 8'h40, (-8)*(-1) gives 8'h08, and 7*(-8) gives 8'hC8. The carry out of the top bit is discarded.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The result and the timing of `done_o` are those of the original operands.
- R8: `product_o` changes only at the edge that raises `done_o`. Between results it holds, whatever the operand inputs do.
- R9: For WIDTH=4, 4'b1011 times 4'b1101 (-5 times -3) gives 8'b00001111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a multiply when idle |
| a_i | input | WIDTH | Multiplicand, signed |
| b_i | input | WIDTH | Multiplier, signed |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse: product valid |
| product_o | output | 2*WIDTH | Signed product, held until the next result |

## Verification
Take the clock edge that samples `start_i` as edge k. `busy_o` is due one cycle later, after edge k. It stays high through the cycles that follow edges k to k+WIDTH-1. `done_o` and the new `product_o` appear together after edge k+WIDTH. The bench drives inputs on the falling edge and samples on the falling edge after each of these rising edges. It checks busy and done in every intermediate cycle and checks the product in the done cycle. One cycle later it checks that done has dropped and that the product has held. This covers all 256 operand pairs, a start issued in the middle of a multiply, and idle cycles in which the operand inputs change.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } smul_state_e;

    // Per-cycle controls from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture operands, clear accumulator
        logic step;   // consume one multiplier bit
        logic last;   // this step consumes the negatively weighted top bit
    } smul_ctl_t;

    // Action chosen for one partial product.
    typedef enum logic [1:0] {
        PP_ZERO = 2'd0,
        PP_ADD  = 2'd1,
        PP_SUB  = 2'd2
    } smul_pp_e;

    function automatic smul_pp_e pp_action(input logic bit_set, input logic top_step);
        if (!bit_set)
            return PP_ZERO;
        return top_step ? PP_SUB : PP_ADD;
    endfunction

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    output smul_ctl_t ctl_o,
    output logic      busy_o,
    output logic      done_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    smul_state_e   state_q;
    logic [CW-1:0] idx_q;
    logic          done_q;

    always_comb begin
        ctl_o.load = (state_q == ST_IDLE) && start_i;
        ctl_o.step = (state_q == ST_RUN);
        ctl_o.last = (state_q == ST_RUN) && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;

    // Checker-side count of busy cycles, used to bound the busy window.
    int unsigned busy_run_q;
    always_ff @(posedge clk) begin
        if (rst)          busy_run_q <= 0;
        else if (busy_o)  busy_run_q <= busy_run_q + 1;
        else              busy_run_q <= 0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_run_q < WIDTH));

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && $past(busy_o) && !ctl_o.last) |=> busy_o);

endmodule

// File: rtl/smul_pp_sel.sv
module smul_pp_sel
    import smul_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [PW-1:0] mcand_i,
    input  logic          bit_i,
    input  logic          top_i,
    output logic [PW-1:0] addend_o
);
    smul_pp_e act;

    always_comb begin
        act = pp_action(bit_i, top_i);
        unique case (act)
            PP_ADD:  addend_o = mcand_i;
            PP_SUB:  addend_o = (~mcand_i) + 1'b1;
            default: addend_o = '0;
        endcase
    end

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
    import smul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  smul_ctl_t            ctl_i,
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    output logic [2*WIDTH-1:0]   product_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    mcand_q;   // sign-extended, shifted to current weight
    logic [WIDTH-1:0] mplier_q;  // remaining multiplier bits, LSB next
    logic [PW-1:0]    acc_q;
    logic [PW-1:0]    prod_q;
    logic [PW-1:0]    addend;
    logic [PW:0]      sum_full;  // one extra bit holds the discarded carry
    logic [PW-1:0]    sum;

    smul_pp_sel #(.PW(PW)) u_pp (
        .mcand_i  (mcand_q),
        .bit_i    (mplier_q[0]),
        .top_i    (ctl_i.last),
        .addend_o (addend)
    );

    always_comb begin
        sum_full = {1'b0, acc_q} + {1'b0, addend};
        sum      = sum_full[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            prod_q   <= '0;
        end else if (ctl_i.load) begin
            mcand_q  <= {{WIDTH{a_i[WIDTH-1]}}, a_i};
            mplier_q <= b_i;
            acc_q    <= '0;
        end else if (ctl_i.step) begin
            acc_q    <= sum;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            if (ctl_i.last)
                prod_q <= sum;
        end
    end

    assign product_o = prod_q;

    p_acc_clear_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> (acc_q == '0));

    p_prod_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_i.last) |-> $stable(prod_q));

    p_ops_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.step && !ctl_i.last) |=> (mcand_q == ($past(mcand_q) << 1)));

endmodule

// File: rtl/seq_smul.sv
module seq_smul
    import smul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2*WIDTH-1:0]   product_o
);
    smul_ctl_t ctl;

    initial begin
        if (WIDTH < 2 || WIDTH > 16)
            $error("seq_smul: WIDTH must lie in 2..16");
    end

    smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    smul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .a_i       (a_i),
        .b_i       (b_i),
        .product_o (product_o)
    );

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(product_o));

endmodule

// File: tb/seq_smul_bench.sv
module seq_smul_bench;
    localparam int N      = 4;
    localparam int PW     = 2 * N;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [N-1:0]  a_i = '0;
    logic [N-1:0]  b_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int n_checks = 0;
    int n_errors = 0;

    seq_smul #(.WIDTH(N)) u_seq_smul (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        int pa;
        int pb;
        int p;
        pa = int'($signed(a));
        pb = int'($signed(b));
        p  = pa * pb;
        return p[PW-1:0];
    endfunction

    // Full transaction; optional mid-run start with other operands (R7).
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                           input bit poke, input string req);
        logic [PW-1:0] exp;
        exp = ref_mul(a, b);
        start_i = 1'b1; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1 && done_o === 1'b0, "R2", {30'd0, busy_o, done_o}, 32'h2);
        for (int i = 1; i < N; i++) begin
            if (poke && i == 1) begin
                start_i = 1'b1; a_i = ~a; b_i = b + 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o === 1'b1 && done_o === 1'b0, "R3", {30'd0, busy_o, done_o}, 32'h2);
        end
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b1, "R3", {30'd0, busy_o, done_o}, 32'h1);
        check(product_o === exp, req, 32'(product_o), 32'(exp));
        @(negedge clk);
        check(done_o === 1'b0, "R4", 32'(done_o), 32'h0);
        check(product_o === exp, "R8", 32'(product_o), 32'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1",
              {22'd0, busy_o, done_o, product_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1",
              {22'd0, busy_o, done_o, product_o}, 32'h0);
    endtask

    task automatic t_stated_case();
        run_mul(4'b1011, 4'b1101, 1'b0, "R9");
        check(product_o === 8'b0000_1111, "R9", 32'(product_o), 32'h0F);
    endtask

    task automatic t_negative_corners();
        run_mul(4'b1000, 4'b1000, 1'b0, "R6");
        check(product_o === 8'h40, "R6", 32'(product_o), 32'h40);
        run_mul(4'b1000, 4'b1111, 1'b0, "R6");
        check(product_o === 8'h08, "R6", 32'(product_o), 32'h08);
        run_mul(4'b0111, 4'b1000, 1'b0, "R6");
        check(product_o === 8'hC8, "R6", 32'(product_o), 32'hC8);
    endtask

    task automatic t_all_pairs();
        for (int i = 0; i < (1 << N); i++)
            for (int j = 0; j < (1 << N); j++)
                run_mul(N'(i), N'(j), 1'b0, "R5");
    endtask

    task automatic t_start_while_busy();
        run_mul(4'b0110, 4'b1011, 1'b1, "R7");
        check(product_o === ref_mul(4'b0110, 4'b1011), "R7", 32'(product_o),
              32'(ref_mul(4'b0110, 4'b1011)));
    endtask

    task automatic t_hold_idle();
        logic [PW-1:0] held;
        run_mul(4'b0011, 4'b1110, 1'b0, "R5");
        held = product_o;
        for (int k = 0; k < 6; k++) begin
            a_i = N'(k * 3); b_i = N'(k + 5);
            @(negedge clk);
            check(product_o === held && busy_o === 1'b0, "R8", 32'(product_o), 32'(held));
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stated_case();
        t_negative_corners();
        t_all_pairs();
        t_start_while_busy();
        t_hold_idle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule